// File: doc/BRIEF.md
# Four-Channel DMA Register Interface

This block is the host-side register file of a four-channel DMA controller. A host reaches it through a 4-bit port offset, an 8-bit data bus and one-cycle read and write strobes. Each channel has a 16-bit address and a 16-bit count. Both are reached through 8-bit ports. A single pointer flip-flop, shared by all channels, decides whether an access hits the low byte or the high byte. The block also keeps a per-channel mode, a four-bit mask, a command byte, software request bits and terminal-count status.

A transfer engine reads the current address, count, mode and mask of each channel from the outputs. It reports each completed transfer on a per-channel step strobe. On a step, the block moves the address up or down by one and decrements the count. When the count runs out, the block records terminal count. It then either reloads the channel from its base copy or masks the channel, depending on the mode.

Top module: `dma_regfile`

## Requirements
- R1: After reset all four mask bits are 1. Mode, command, request and terminal-count status are 0. The byte pointer selects the low byte.
- R2: Each read or write at offsets 0x0 to 0x7 reaches one byte of a 16-bit value and then toggles the byte pointer. The first access after the pointer is cleared hits the low byte and the next hits the high byte.
- R3: A write to offset 0xC clears the byte pointer, so the next channel access hits the low byte.
- R4: Offset 2n is the address of channel n and offset 2n+1 is its count. A write loads the selected byte into both the base and the current copy. A read returns the selected byte of the current copy.
- R5: A write to offset 0xB stores data bits 7:2 as the mode of the channel that data bits 1:0 name. The mode output holds them as bits 5:0. Bits 3:2 of data give the direction: 01 is I/O to memory, 10 is memory to I/O. Bit 4 enables autoinit. Bit 5 selects address decrement. Bits 7:6 equal to 11 select cascade.
- R6: A write to offset 0xA sets the mask bit of the channel named by data bits 1:0 to the value of data bit 2.
- R7: A write to offset 0xE clears all mask bits. A write to offset 0xF loads the mask from data bits 3:0.
- R8: A write to offset 0x8 stores the data byte as the command, and the command output shows it.
- R9: A write to offset 0x9 sets or clears the request bit of the channel named by data bits 1:0, according to data bit 2. The request bits appear in status bits 7:4.
- R10: A step on an unmasked channel decrements its count by 1. The same step adds 1 to its address, or subtracts 1 when the mode's decrement bit is set. A step on a masked channel changes nothing.
- R11: A step that finds the count at 0 is terminal. It sets that channel's status bit and clears its request bit. Without autoinit the count wraps to 0xFFFF, the address advances, and the mask bit is set. With autoinit the current address and count are reloaded from the base copy and the mask bit is left unchanged.
- R12: A read of offset 0x8 returns the request bits in 7:4 and the terminal-count bits in 3:0. It then clears the terminal-count bits.
- R13: A write to offset 0xD sets all mask bits and clears the command, mode, request, status and byte pointer. It leaves the address and count registers unchanged. A read of offset 0xD returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Port offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| step_i | input | 4 | Per-channel transfer-done strobe from the engine |
| rdata_o | output | 8 | Read data, valid in the same cycle as rd_i |
| cur_addr_o | output | 64 | Current address; channel n at bits 16n+15:16n |
| cur_cnt_o | output | 64 | Current count; channel n at bits 16n+15:16n |
| mode_o | output | 24 | Mode; channel n at bits 6n+5:6n |
| mask_o | output | 4 | Mask bit per channel |
| cmd_o | output | 8 | Command register |

## Verification
The bench writes a single stray byte and then clears the pointer, to show that the next write lands in the low byte. A pointer that ignored the clear would put that byte in the high half and shift every later value. It runs the terminal step once without autoinit and once with it. A swapped reload would show as a count of 0xFFFF where the base value was expected, or as a mask bit left in the wrong state. It reads the status twice and steps a masked channel. A status that does not clear, or a mask that does not gate the step, shows up as stale terminal bits or as a count that moved. Master clear is checked both for what it must clear and for the address registers it must keep.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
  localparam int unsigned NCH = 4;
  localparam int unsigned CW  = $clog2(NCH);
  localparam int unsigned MW  = 6;
  localparam int unsigned MODE_AUTO_BIT = 2;  // data bit 4
  localparam int unsigned MODE_DEC_BIT  = 3;  // data bit 5
  localparam logic [3:0] OFS_CMD    = 4'h8;
  localparam logic [3:0] OFS_REQ    = 4'h9;
  localparam logic [3:0] OFS_MASK1  = 4'hA;
  localparam logic [3:0] OFS_MODE   = 4'hB;
  localparam logic [3:0] OFS_PCLR   = 4'hC;
  localparam logic [3:0] OFS_MCLR   = 4'hD;
  localparam logic [3:0] OFS_MZERO  = 4'hE;
  localparam logic [3:0] OFS_MALL   = 4'hF;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tgl_i,
  output logic hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_o <= 1'b0;
    else if (clr_i) hi_o <= 1'b0;
    else if (tgl_i) hi_o <= ~hi_o;
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int unsigned DW = 8,
  localparam int unsigned VW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_addr_i,
  input  logic          ld_cnt_i,
  input  logic          hi_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          step_i,
  input  logic          dec_i,
  input  logic          auto_i,
  output logic [VW-1:0] cur_addr_o,
  output logic [VW-1:0] cur_cnt_o,
  output logic          tc_o
);
  logic [VW-1:0] base_addr_q, base_cnt_q;
  logic          reload;

  assign tc_o   = step_i && (cur_cnt_o == '0);
  assign reload = tc_o && auto_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      cur_addr_o  <= '0;
    end else if (ld_addr_i) begin
      if (hi_i) begin
        base_addr_q[DW +: DW] <= wdata_i;
        cur_addr_o[DW +: DW]  <= wdata_i;
      end else begin
        base_addr_q[0 +: DW] <= wdata_i;
        cur_addr_o[0 +: DW]  <= wdata_i;
      end
    end else if (step_i) begin
      if (reload)     cur_addr_o <= base_addr_q;
      else if (dec_i) cur_addr_o <= cur_addr_o - 1'b1;
      else            cur_addr_o <= cur_addr_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_cnt_q <= '0;
      cur_cnt_o  <= '0;
    end else if (ld_cnt_i) begin
      if (hi_i) begin
        base_cnt_q[DW +: DW] <= wdata_i;
        cur_cnt_o[DW +: DW]  <= wdata_i;
      end else begin
        base_cnt_q[0 +: DW] <= wdata_i;
        cur_cnt_o[0 +: DW]  <= wdata_i;
      end
    end else if (step_i) begin
      if (reload) cur_cnt_o <= base_cnt_q;
      else        cur_cnt_o <= cur_cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_reg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [3:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              sts_rd_i,
  input  logic [NCH-1:0]    tc_i,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH*MW-1:0] mode_o,
  output logic [DW-1:0]     cmd_o,
  output logic [NCH-1:0]    req_o,
  output logic [NCH-1:0]    tc_sts_o
);
  logic [MW-1:0] mode_q [NCH];
  logic [CW-1:0] sel;
  logic          mclr;

  assign sel  = wdata_i[CW-1:0];
  assign mclr = wr_i && (addr_i == OFS_MCLR);

  for (genvar i = 0; i < NCH; i++) begin : g_mode_out
    assign mode_o[i*MW +: MW] = mode_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o   <= '1;
      cmd_o    <= '0;
      req_o    <= '0;
      tc_sts_o <= '0;
      for (int i = 0; i < NCH; i++) mode_q[i] <= '0;
    end else if (mclr) begin
      mask_o   <= '1;
      cmd_o    <= '0;
      req_o    <= '0;
      tc_sts_o <= '0;
      for (int i = 0; i < NCH; i++) mode_q[i] <= '0;
    end else begin
      if (wr_i && addr_i == OFS_CMD)   cmd_o <= wdata_i;
      if (wr_i && addr_i == OFS_MODE)  mode_q[sel] <= wdata_i[DW-1:2];
      if (wr_i && addr_i == OFS_MASK1) mask_o[sel] <= wdata_i[2];
      if (wr_i && addr_i == OFS_MZERO) mask_o <= '0;
      if (wr_i && addr_i == OFS_MALL)  mask_o <= wdata_i[NCH-1:0];
      if (wr_i && addr_i == OFS_REQ)   req_o[sel] <= wdata_i[2];
      tc_sts_o <= (sts_rd_i ? '0 : tc_sts_o) | tc_i;
      // terminal events take priority over same-cycle host writes
      for (int i = 0; i < NCH; i++) begin
        if (tc_i[i]) begin
          req_o[i] <= 1'b0;
          if (!mode_q[i][MODE_AUTO_BIT]) mask_o[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_reg_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned VW = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [NCH-1:0]    step_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NCH*VW-1:0] cur_addr_o,
  output logic [NCH*VW-1:0] cur_cnt_o,
  output logic [NCH*MW-1:0] mode_o,
  output logic [NCH-1:0]    mask_o,
  output logic [DW-1:0]     cmd_o
);
  logic           is_chan, ptr_hi, ptr_clr, sts_rd;
  logic [CW-1:0]  ch;
  logic [NCH-1:0] step_eff, tc, req, tc_sts;
  logic [VW-1:0]  rd_val;

  assign is_chan  = ~addr_i[3];
  assign ch       = addr_i[CW:1];
  assign ptr_clr  = wr_i && (addr_i == OFS_PCLR || addr_i == OFS_MCLR);
  assign sts_rd   = rd_i && (addr_i == OFS_CMD);
  assign step_eff = step_i & ~mask_o;

  dma_byte_ptr u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ptr_clr),
    .tgl_i ((wr_i || rd_i) && is_chan),
    .hi_o  (ptr_hi)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    logic hit;
    assign hit = wr_i && is_chan && (ch == CW'(n));
    dma_chan #(.DW(DW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_addr_i (hit && !addr_i[0]),
      .ld_cnt_i  (hit && addr_i[0]),
      .hi_i      (ptr_hi),
      .wdata_i   (wdata_i),
      .step_i    (step_eff[n]),
      .dec_i     (mode_o[n*MW + MODE_DEC_BIT]),
      .auto_i    (mode_o[n*MW + MODE_AUTO_BIT]),
      .cur_addr_o(cur_addr_o[n*VW +: VW]),
      .cur_cnt_o (cur_cnt_o[n*VW +: VW]),
      .tc_o      (tc[n])
    );
  end

  dma_ctrl #(.DW(DW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .sts_rd_i(sts_rd),
    .tc_i    (tc),
    .mask_o  (mask_o),
    .mode_o  (mode_o),
    .cmd_o   (cmd_o),
    .req_o   (req),
    .tc_sts_o(tc_sts)
  );

  assign rd_val = addr_i[0] ? cur_cnt_o[ch*VW +: VW] : cur_addr_o[ch*VW +: VW];

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (is_chan)                  rdata_o = ptr_hi ? rd_val[DW +: DW] : rd_val[0 +: DW];
      else if (addr_i == OFS_CMD)   rdata_o = DW'({req, tc_sts});
    end
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
  import dma_reg_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned VW = 2 * DW
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [NCH-1:0]    step_i,
  input logic [NCH*VW-1:0] cur_cnt_o,
  input logic [NCH-1:0]    mask_o,
  input logic [DW-1:0]     cmd_o,
  input logic              ptr_hi_i,
  input logic [NCH-1:0]    tc_sts_i
);
  AST_PTR_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || rd_i) && !addr_i[3] |=> ptr_hi_i != $past(ptr_hi_i)); // R2
  AST_PTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFS_PCLR |=> !ptr_hi_i); // R3
  AST_MASK_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFS_MASK1 && step_i == '0
      |=> mask_o[$past(wdata_i[CW-1:0])] == $past(wdata_i[2])); // R6
  AST_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFS_MZERO && step_i == '0 |=> mask_o == '0); // R7
  AST_STEP_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && step_i[0] && mask_o[0] |=> $stable(cur_cnt_o[VW-1:0])); // R10
  AST_STS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == OFS_CMD && step_i == '0 |=> tc_sts_i == '0); // R12
  AST_MCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == OFS_MCLR |=> mask_o == '1 && cmd_o == '0 && !ptr_hi_i); // R13
endmodule

bind dma_regfile dma_regfile_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .step_i   (step_i),
  .cur_cnt_o(cur_cnt_o),
  .mask_o   (mask_o),
  .cmd_o    (cmd_o),
  .ptr_hi_i (ptr_hi),
  .tc_sts_i (tc_sts)
);

// File: tb/dma_regfile_test.sv
module dma_regfile_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [3:0]  step_i = '0;
  logic [7:0]  rdata_o;
  logic [63:0] cur_addr_o, cur_cnt_o;
  logic [23:0] mode_o;
  logic [3:0]  mask_o;
  logic [7:0]  cmd_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  dma_regfile uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] ofs, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = ofs; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] ofs, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = ofs; rd_i = 1'b1;
    #2 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic do_step(input logic [3:0] s);
    @(negedge clk_i);
    step_i = s;
    @(negedge clk_i);
    step_i = '0;
  endtask

  function automatic logic [15:0] ch_addr(input int n);
    return cur_addr_o[n*16 +: 16];
  endfunction
  function automatic logic [15:0] ch_cnt(input int n);
    return cur_cnt_o[n*16 +: 16];
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    check("R1 mask", mask_o, 4'hF);
    check("R1 cmd", cmd_o, 8'h00);
    check("R1 mode", mode_o, 24'h0);
    bus_rd(4'h8, d);
    check("R1 status", d, 8'h00);
  endtask

  task automatic t_addr_cnt;
    logic [7:0] d;
    bus_wr(4'hC, 8'h00);
    bus_wr(4'h4, 8'h34);
    bus_wr(4'h4, 8'h12);
    check("R4 ch2 address", ch_addr(2), 16'h1234);
    bus_wr(4'h5, 8'hFF);
    bus_wr(4'h5, 8'h00);
    check("R4 ch2 count", ch_cnt(2), 16'h00FF);
    bus_rd(4'h5, d);
    check("R2 count low read", d, 8'hFF);
    bus_rd(4'h5, d);
    check("R2 count high read", d, 8'h00);
    bus_wr(4'hC, 8'h00);
    bus_wr(4'h4, 8'hAA);
    bus_wr(4'hC, 8'h00);
    bus_wr(4'h4, 8'h55);
    check("R3 pointer clear", ch_addr(2), 16'h1255);
    bus_wr(4'hC, 8'h00);
  endtask

  task automatic t_mode;
    bus_wr(4'hB, 8'h45);
    check("R5 ch1 io-to-mem", mode_o[6 +: 6], 6'h11);
    bus_wr(4'hB, 8'h4B);
    check("R5 ch3 mem-to-io", mode_o[18 +: 6], 6'h12);
    bus_wr(4'hB, 8'hC0);
    check("R5 ch0 cascade", mode_o[0 +: 6], 6'h30);
    bus_wr(4'hB, 8'h56);
    check("R5 ch2 autoinit", mode_o[12 +: 6], 6'h15);
  endtask

  task automatic t_mask;
    bus_wr(4'hA, 8'h01);
    check("R6 unmask ch1", mask_o, 4'hD);
    bus_wr(4'hA, 8'h05);
    check("R6 mask ch1", mask_o, 4'hF);
    bus_wr(4'hE, 8'h00);
    check("R7 clear all", mask_o, 4'h0);
    bus_wr(4'hF, 8'hFA);
    check("R7 write all", mask_o, 4'hA);
  endtask

  task automatic t_cmd;
    bus_wr(4'h8, 8'h5A);
    check("R8 command", cmd_o, 8'h5A);
  endtask

  task automatic t_req;
    logic [7:0] d;
    bus_wr(4'h9, 8'h05);
    bus_rd(4'h8, d);
    check("R9 request set", d, 8'h20);
    bus_wr(4'h9, 8'h01);
    bus_rd(4'h8, d);
    check("R9 request clear", d, 8'h00);
  endtask

  task automatic t_step;
    bus_wr(4'hC, 8'h00);
    bus_wr(4'h0, 8'h10);
    bus_wr(4'h0, 8'h00);
    bus_wr(4'h1, 8'h02);
    bus_wr(4'h1, 8'h00);
    bus_wr(4'hB, 8'h44);
    bus_wr(4'hA, 8'h00);
    do_step(4'h1);
    check("R10 inc address", ch_addr(0), 16'h0011);
    check("R10 count dec", ch_cnt(0), 16'h0001);
    bus_wr(4'hA, 8'h04);
    do_step(4'h1);
    check("R10 masked step address", ch_addr(0), 16'h0011);
    check("R10 masked step count", ch_cnt(0), 16'h0001);
    bus_wr(4'hB, 8'h64);
    bus_wr(4'hA, 8'h00);
    do_step(4'h1);
    check("R10 dec address", ch_addr(0), 16'h0010);
    check("R10 count to zero", ch_cnt(0), 16'h0000);
  endtask

  task automatic t_tc;
    logic [7:0] d;
    bus_wr(4'h9, 8'h04);
    do_step(4'h1);
    check("R11 wrap count", ch_cnt(0), 16'hFFFF);
    check("R11 address after tc", ch_addr(0), 16'h000F);
    check("R11 mask set", mask_o[0], 1'b1);
    bus_rd(4'h8, d);
    check("R12 status tc ch0 req cleared", d, 8'h01);
    bus_rd(4'h8, d);
    check("R12 status cleared", d, 8'h00);
    bus_wr(4'hC, 8'h00);
    bus_wr(4'h6, 8'h00);
    bus_wr(4'h6, 8'h80);
    bus_wr(4'h7, 8'h00);
    bus_wr(4'h7, 8'h00);
    bus_wr(4'hB, 8'h57);
    bus_wr(4'hA, 8'h03);
    do_step(4'h8);
    check("R11 autoinit address", ch_addr(3), 16'h8000);
    check("R11 autoinit count", ch_cnt(3), 16'h0000);
    check("R11 autoinit mask kept", mask_o[3], 1'b0);
    bus_rd(4'h8, d);
    check("R12 status tc ch3", d, 8'h08);
  endtask

  task automatic t_mclr;
    logic [7:0] d;
    bus_wr(4'h8, 8'h77);
    bus_wr(4'h9, 8'h06);
    bus_wr(4'hC, 8'h00);
    bus_wr(4'h4, 8'h66);
    bus_wr(4'hD, 8'h00);
    check("R13 mask", mask_o, 4'hF);
    check("R13 cmd", cmd_o, 8'h00);
    check("R13 mode", mode_o, 24'h0);
    check("R13 address kept", ch_addr(2), 16'h1266);
    bus_rd(4'h8, d);
    check("R13 status", d, 8'h00);
    bus_rd(4'hD, d);
    check("R13 temp read", d, 8'h00);
    bus_wr(4'h4, 8'h99);
    check("R13 pointer cleared", ch_addr(2), 16'h1299);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_addr_cnt();
    t_mode();
    t_mask();
    t_cmd();
    t_req();
    t_step();
    t_tc();
    t_mclr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule